// File: doc/BRIEF.md
# Trap Exception Frame Builder

This block turns a trap event raised by instruction execution into an exception stack frame. It accepts one trap request at a time: the trap kind, a 4-bit operand carried by the software trap instruction, the address of the trapping instruction, the address of the next instruction, the status register and the trace-enable flag. From these it forms the exception vector number. It then streams the frame as 16-bit words over a valid/ready write port. The first word streamed belongs at the highest stack address, and each later word sits one slot lower.

Software traps get a short frame that holds the status register, the return address and a combined format/vector word. All other trap kinds (conditional trap, overflow trap, bounds check, divide by zero) get a long frame that also holds the address of the faulting instruction. If tracing was enabled when the trap was accepted, the block raises a trace request after the frame is complete. The trap is therefore handled first and the trace follows it. Fetching the handler is left to the surrounding core.

Top module: `trap_frame_builder`

## Requirements
- R1: While and after reset, with no request accepted: `wr_valid`, `frame_done` and `trace_req` are low, `trap_ready` is high and `vector_o` is 0.
- R2: Trap kind codes are 0 software trap, 1 conditional trap, 2 overflow trap, 3 bounds check and 4 divide by zero. For kind 0 the vector is 32 plus `trap_opnd`.
- R3: Fixed vectors apply to the other kinds: 5 for divide by zero, 6 for bounds check, 7 for conditional and overflow traps.
- R4: Kind 0 emits 4 words and every other kind emits 6 words. The emission order (highest address first) is: fault low half, fault high half (long frames only), then format/vector word, PC low half, PC high half, status register. Read from the stack top, the fault address is therefore the fifth and sixth word.
- R5: In the format/vector word, bits 15:12 hold the format (0 for a short frame, 2 for a long frame), bits 9:2 hold the vector, and bits 11:10 and 1:0 are zero.
- R6: The saved PC is `next_pc`. The saved fault address is `cur_pc`, and it is stored only for kinds other than 0.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid` stays high and `wr_data` does not change. No word is lost or repeated.
- R8: `frame_done` is a one-cycle pulse in the cycle after the handshake of the last word of a frame.
- R9: If `trace_en` was high when the request was accepted, `trace_req` pulses for one cycle, one cycle after `frame_done`. Otherwise `trace_req` stays low.
- R10: A request is ignored when its kind code is 5 to 7. A request is also ignored when `trap_ready` is low, and `trap_ready` is low while a frame is being emitted.
- R11: `vector_o` takes the vector of a request when that request is accepted and holds it until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | Trap request present |
| trap_ready | output | 1 | Block idle, request will be accepted |
| trap_kind | input | 3 | Trap kind code |
| trap_opnd | input | 4 | Operand of the software trap instruction |
| cur_pc | input | 32 | Address of the trapping instruction |
| next_pc | input | 32 | Address of the following instruction |
| sr_in | input | 16 | Status register copy |
| trace_en | input | 1 | Tracing enabled at instruction start |
| wr_valid | output | 1 | Stack write word valid |
| wr_ready | input | 1 | Stack write word taken |
| wr_data | output | 16 | Stack write word |
| frame_done | output | 1 | Last frame word written |
| trace_req | output | 1 | Trace exception request following the trap |
| vector_o | output | 8 | Vector number of the last accepted trap |

## Verification
The bench sends every trap kind, including both ends of the operand range, with the write port always ready, stalling in a pattern, and held off. A block that stored a fault address for the software trap, or left it out for another kind, would shift every later word, and the scoreboard would report a wrong word or a word too many or too few. A block with a wrong format nibble or vector offset would fail on the format/vector word. A trace request that fires together with `frame_done`, or fires without tracing enabled, fails the timing check. The bench also raises requests with unused kind codes and while a frame is being emitted. A design that accepted either would emit unexpected words or change `vector_o`.

// File: rtl/trapfb_pkg.sv
package trapfb_pkg;
  typedef enum logic [2:0] {
    TK_SWTRAP = 3'd0,
    TK_COND   = 3'd1,
    TK_OVF    = 3'd2,
    TK_BOUND  = 3'd3,
    TK_DIVZ   = 3'd4
  } trap_kind_e;

  localparam int unsigned FMT_W     = 4;
  localparam logic [3:0]  FMT_SHORT = 4'd0;
  localparam logic [3:0]  FMT_LONG  = 4'd2;

  function automatic logic kind_known(input logic [2:0] k);
    return k <= 3'd4;
  endfunction
endpackage

// File: rtl/trapfb_vector.sv
module trapfb_vector
  import trapfb_pkg::*;
#(
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned OPND_W    = 4,
  parameter int unsigned TRAP_BASE = 32,
  parameter int unsigned VEC_DIVZ  = 5,
  parameter int unsigned VEC_BOUND = 6,
  parameter int unsigned VEC_COND  = 7
) (
  input  logic [2:0]        kind,
  input  logic [OPND_W-1:0] opnd,
  output logic [VEC_W-1:0]  vec,
  output logic              long_frame,
  output logic              known
);
  always_comb begin
    known      = kind_known(kind);
    long_frame = (kind != TK_SWTRAP);
    unique case (kind)
      TK_SWTRAP:      vec = VEC_W'(TRAP_BASE) + VEC_W'(opnd);
      TK_COND, TK_OVF: vec = VEC_W'(VEC_COND);
      TK_BOUND:       vec = VEC_W'(VEC_BOUND);
      TK_DIVZ:        vec = VEC_W'(VEC_DIVZ);
      default:        vec = '0;
    endcase
  end

  always_comb begin
    if (kind == TK_SWTRAP)
      assert_swtrap_range_R2: assert (vec >= VEC_W'(TRAP_BASE));
  end
endmodule

// File: rtl/trapfb_pack.sv
module trapfb_pack
  import trapfb_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned VEC_W  = 8,
  localparam int unsigned HALVES = ADDR_W / WORD_W,
  localparam int unsigned MAXLEN = 2 * HALVES + 2,
  localparam int unsigned LEN_W  = $clog2(MAXLEN + 1),
  localparam int unsigned PAD_W  = WORD_W - FMT_W - VEC_W - 2
) (
  input  logic [VEC_W-1:0]              vec,
  input  logic                          long_frame,
  input  logic [ADDR_W-1:0]             fault_pc,
  input  logic [ADDR_W-1:0]             ret_pc,
  input  logic [WORD_W-1:0]             sr,
  output logic [MAXLEN-1:0][WORD_W-1:0] frame,
  output logic [LEN_W-1:0]              len
);
  logic [WORD_W-1:0] fv_word;

  always_comb begin
    fv_word = {(long_frame ? FMT_LONG : FMT_SHORT), {PAD_W{1'b0}}, vec, 2'b00};
    frame   = '0;
    if (long_frame) begin
      for (int h = 0; h < HALVES; h++) begin
        frame[h]              = fault_pc[h*WORD_W +: WORD_W];
        frame[HALVES + 1 + h] = ret_pc[h*WORD_W +: WORD_W];
      end
      frame[HALVES]         = fv_word;
      frame[2*HALVES + 1]   = sr;
      len = LEN_W'(2*HALVES + 2);
    end else begin
      frame[0] = fv_word;
      for (int h = 0; h < HALVES; h++)
        frame[1 + h] = ret_pc[h*WORD_W +: WORD_W];
      frame[HALVES + 1] = sr;
      len = LEN_W'(HALVES + 2);
    end
  end
endmodule

// File: rtl/trapfb_seq.sv
module trapfb_seq #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned MAXLEN = 6,
  localparam int unsigned LEN_W = $clog2(MAXLEN + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [MAXLEN-1:0][WORD_W-1:0] frame,
  input  logic [LEN_W-1:0]              len,
  input  logic                          trace_in,
  output logic                          idle,
  output logic                          wr_valid,
  input  logic                          wr_ready,
  output logic [WORD_W-1:0]             wr_data,
  output logic                          done,
  output logic                          trace_req
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_TRACE} seq_state_e;

  seq_state_e                    state;
  logic [MAXLEN-1:0][WORD_W-1:0] frame_q;
  logic [LEN_W-1:0]              len_q;
  logic [LEN_W-1:0]              idx;
  logic                          trace_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      frame_q   <= '0;
      len_q     <= '0;
      idx       <= '0;
      trace_q   <= 1'b0;
      done      <= 1'b0;
      trace_req <= 1'b0;
    end else begin
      done      <= 1'b0;
      trace_req <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          frame_q <= frame;
          len_q   <= len;
          trace_q <= trace_in;
          idx     <= '0;
          state   <= S_SEND;
        end
        S_SEND: if (wr_ready) begin
          if (idx == len_q - 1'b1) begin
            done  <= 1'b1;
            state <= trace_q ? S_TRACE : S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_TRACE: begin
          trace_req <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign idle     = (state == S_IDLE);
  assign wr_valid = (state == S_SEND);

  always_comb begin
    wr_data = '0;
    for (int i = 0; i < MAXLEN; i++)
      if (idx == LEN_W'(i)) wr_data = frame_q[i];
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr_valid && wr_ready));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_trace_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    trace_req |-> $past(done));
endmodule

// File: rtl/trap_frame_builder.sv
module trap_frame_builder #(
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned VEC_W     = 8,
  parameter int unsigned OPND_W    = 4,
  parameter int unsigned TRAP_BASE = 32,
  parameter int unsigned VEC_DIVZ  = 5,
  parameter int unsigned VEC_BOUND = 6,
  parameter int unsigned VEC_COND  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_valid,
  output logic              trap_ready,
  input  logic [2:0]        trap_kind,
  input  logic [OPND_W-1:0] trap_opnd,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [WORD_W-1:0] sr_in,
  input  logic              trace_en,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [WORD_W-1:0] wr_data,
  output logic              frame_done,
  output logic              trace_req,
  output logic [VEC_W-1:0]  vector_o
);
  localparam int unsigned HALVES = ADDR_W / WORD_W;
  localparam int unsigned MAXLEN = 2 * HALVES + 2;
  localparam int unsigned LEN_W  = $clog2(MAXLEN + 1);

  logic [VEC_W-1:0]              vec;
  logic                          long_frame;
  logic                          known;
  logic [MAXLEN-1:0][WORD_W-1:0] frame;
  logic [LEN_W-1:0]              len;
  logic                          accept;

  trapfb_vector #(
    .VEC_W(VEC_W), .OPND_W(OPND_W), .TRAP_BASE(TRAP_BASE),
    .VEC_DIVZ(VEC_DIVZ), .VEC_BOUND(VEC_BOUND), .VEC_COND(VEC_COND)
  ) u_vector (
    .kind(trap_kind), .opnd(trap_opnd), .vec(vec),
    .long_frame(long_frame), .known(known)
  );

  trapfb_pack #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_pack (
    .vec(vec), .long_frame(long_frame), .fault_pc(cur_pc), .ret_pc(next_pc),
    .sr(sr_in), .frame(frame), .len(len)
  );

  assign accept = trap_valid && trap_ready && known;

  trapfb_seq #(.WORD_W(WORD_W), .MAXLEN(MAXLEN)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .frame(frame), .len(len),
    .trace_in(trace_en), .idle(trap_ready), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .done(frame_done),
    .trace_req(trace_req)
  );

  always_ff @(posedge clk) begin
    if (rst)         vector_o <= '0;
    else if (accept) vector_o <= vec;
  end

  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> !trap_ready);
  assert_vector_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !trap_ready |=> $stable(vector_o));
endmodule

// File: tb/test_trap_frame_builder.sv
module test_trap_frame_builder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trap_valid = 1'b0;
  logic        trap_ready;
  logic [2:0]  trap_kind = '0;
  logic [3:0]  trap_opnd = '0;
  logic [31:0] cur_pc = '0;
  logic [31:0] next_pc = '0;
  logic [15:0] sr_in = '0;
  logic        trace_en = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [15:0] wr_data;
  logic        frame_done;
  logic        trace_req;
  logic [7:0]  vector_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  int ready_mode = 0;
  int cyc = 0;

  logic [17:0] exp_q[$];   // {last, trace, word}
  bit  done_pend = 0;
  int  trace_cnt = 0;
  bit  stall_prev = 0;
  logic [15:0] stall_data;

  always #2 clk = ~clk;

  trap_frame_builder i_trap_frame_builder (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_ready(trap_ready),
    .trap_kind(trap_kind), .trap_opnd(trap_opnd), .cur_pc(cur_pc),
    .next_pc(next_pc), .sr_in(sr_in), .trace_en(trace_en),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .frame_done(frame_done), .trace_req(trace_req), .vector_o(vector_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_vec(input logic [2:0] k, input logic [3:0] op);
    case (k)
      3'd0: return 8'd32 + {4'd0, op};
      3'd1, 3'd2: return 8'd7;
      3'd3: return 8'd6;
      default: return 8'd5;
    endcase
  endfunction

  // write port ready pattern
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (ready_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = (cyc % 3) != 1;
      default: wr_ready = 1'b0;
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      bit exp_d, exp_t;
      exp_d = done_pend; done_pend = 0;
      exp_t = (trace_cnt == 1);
      if (trace_cnt > 0) trace_cnt--;
      if (exp_d || frame_done) chk(frame_done == exp_d, "R8 done pulse", 32'(frame_done), 32'(exp_d));
      if (exp_t || trace_req)  chk(trace_req == exp_t, "R9 trace after trap", 32'(trace_req), 32'(exp_t));
      if (stall_prev)
        chk(wr_valid && wr_data == stall_data, "R7 hold under stall", {15'd0, wr_valid, wr_data}, {16'd1, stall_data});
      stall_prev = wr_valid && !wr_ready;
      stall_data = wr_data;
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 R10 unexpected word", 32'(wr_data), 32'hFFFF_FFFF);
        end else begin
          logic [17:0] e;
          e = exp_q.pop_front();
          chk(wr_data == e[15:0], "R4 R5 R6 frame word", 32'(wr_data), 32'(e[15:0]));
          if (e[17]) begin
            done_pend = 1;
            if (e[16]) trace_cnt = 2;
          end
        end
      end
    end
  end

  task automatic push_frame(input logic [2:0] k, input logic [3:0] op,
                            input logic [31:0] cp, input logic [31:0] np,
                            input logic [15:0] s, input bit tr);
    logic [15:0] w[$];
    logic [7:0]  v;
    v = exp_vec(k, op);
    if (k != 3'd0) begin
      w.push_back(cp[15:0]);
      w.push_back(cp[31:16]);
      w.push_back({4'd2, 2'b00, v, 2'b00});
    end else begin
      w.push_back({4'd0, 2'b00, v, 2'b00});
    end
    w.push_back(np[15:0]);
    w.push_back(np[31:16]);
    w.push_back(s);
    foreach (w[i]) exp_q.push_back({(i == w.size() - 1), tr, w[i]});
  endtask

  task automatic send(input logic [2:0] k, input logic [3:0] op,
                      input logic [31:0] cp, input logic [31:0] np,
                      input logic [15:0] s, input bit tr);
    @(posedge clk); #1;
    trap_kind = k; trap_opnd = op; cur_pc = cp; next_pc = np;
    sr_in = s; trace_en = tr; trap_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (trap_ready) break;
    end
    push_frame(k, op, cp, np, s, tr);
    @(posedge clk); #1;
    trap_valid = 1'b0;
    @(negedge clk);
    chk(vector_o == exp_vec(k, op), "R2 R3 R11 vector", 32'(vector_o), 32'(exp_vec(k, op)));
  endtask

  task automatic drain();
    forever begin
      @(negedge clk);
      if (exp_q.size() == 0 && trap_ready && !done_pend && trace_cnt == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] vhold;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!wr_valid && !frame_done && !trace_req, "R1 outputs idle", {wr_valid, frame_done, trace_req}, 0);
    chk(trap_ready, "R1 ready", 32'(trap_ready), 1);
    chk(vector_o == 0, "R1 vector", 32'(vector_o), 0);

    // R2 R4 R5 R6: software trap, both operand ends
    send(3'd0, 4'd0, 32'h0000_1000, 32'h0000_1002, 16'h2700, 0);
    drain();
    ready_mode = 1;
    send(3'd0, 4'd15, 32'hABCD_0100, 32'hABCD_0102, 16'h0015, 0);
    drain();
    // R3 R6: long frames with stalls, R9 with tracing
    send(3'd1, 4'd3, 32'h1234_5678, 32'h1234_567C, 16'h8000, 0);
    drain();
    send(3'd2, 4'd0, 32'h0F0F_F0F0, 32'h0F0F_F0F2, 16'hA5A5, 1);
    drain();
    ready_mode = 0;
    send(3'd3, 4'd9, 32'hFFFF_FFFE, 32'h0000_0002, 16'h0700, 1);
    drain();
    send(3'd4, 4'd1, 32'h0004_0000, 32'h0004_0004, 16'h2000, 0);
    drain();
    send(3'd0, 4'd7, 32'h0000_2222, 32'h0000_2224, 16'h3333, 1);
    // back-to-back request right behind a trace frame
    send(3'd4, 4'd0, 32'h0000_3000, 32'h0000_3004, 16'h0001, 0);
    drain();

    // R10: unknown kind codes are ignored
    vhold = vector_o;
    for (int kc = 5; kc < 8; kc++) begin
      @(posedge clk); #1;
      trap_kind = 3'(kc); trap_valid = 1'b1; trace_en = 1'b1;
      repeat (3) @(posedge clk);
      #1 trap_valid = 1'b0;
      @(negedge clk);
      chk(!wr_valid, "R10 unknown kind no frame", 32'(wr_valid), 0);
      chk(vector_o == vhold, "R10 unknown kind vector", 32'(vector_o), 32'(vhold));
    end
    repeat (4) @(negedge clk);
    chk(!trace_req && !wr_valid, "R10 unknown kind quiet", {trace_req, wr_valid}, 0);

    // R10: request while busy is ignored
    ready_mode = 2;
    send(3'd3, 4'd0, 32'h0000_4000, 32'h0000_4004, 16'h0444, 0);
    @(posedge clk); #1;
    trap_kind = 3'd0; trap_opnd = 4'd5; trap_valid = 1'b1; trace_en = 1'b1;
    repeat (3) @(posedge clk);
    #1 trap_valid = 1'b0;
    @(negedge clk);
    chk(!trap_ready, "R10 busy not ready", 32'(trap_ready), 0);
    ready_mode = 0;
    drain();
    chk(vector_o == 8'd6, "R11 vector held after busy request", 32'(vector_o), 6);
    chk(exp_q.size() == 0, "R4 all words seen", exp_q.size(), 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule